// File: doc/BRIEF.md
# Coherence Command Packet Generator

This block sits on the memory-cache side of a cache-coherence network. It takes one coherence request at a time and turns it into a packet of command flits on a valid/ready port. There are three request kinds: invalidate a line in selected L1 caches, update words of a line in selected L1 caches, and invalidate a line in every L1 cache inside a rectangle of clusters. The port also carries an end-of-packet marker.

The line index does not go in the address. Its low 32 bits go on the write-data bus and its top 2 bits go on the low byte-enable lanes of the first flit. For targeted packets, the address carries the destination L1 identifier, left-aligned, plus flag bits that give the request kind and the cache type. For a broadcast, the address carries the rectangle corners instead. An update packet adds a flit holding the index of the first word, then one flit for each data word.

Only one request is handled at a time. The request port stays not-ready from the moment a request is accepted until the last flit of its packet has been taken. Malformed update lengths are rejected or clamped, and in both cases an error pulse is raised.

Top module: `coh_cmd_gen`

## Requirements
- R1: While reset is held and right after it is released, `cmd_valid_o` and `err_o` are 0 and `req_ready_o` is 1.
- R2: Every emitted flit carries `cmd_cmd_o` = 2'b10 (write).
- R3: The first flit of every packet carries line index bits [31:0] on `cmd_wdata_o`, index bits [33:32] on `cmd_be_o[1:0]`, and 0 on `cmd_be_o[3:2]`.
- R4: A request of kind 2'b00 (targeted invalidate) or kind 2'b10 (broadcast invalidate) produces exactly one flit, and that flit has `cmd_eop_o` = 1.
- R5: A request of kind 2'b01 (update) with word count N in 1..16 produces 2+N flits. Flit 1 has `cmd_wdata_o` = the first-word index zero-extended. Flits 2..N+1 carry `req_words_i` words 0..N-1, where word k is bits [32k+31:32k]. Flits after the first have `cmd_be_o` = 4'hF. `cmd_eop_o` is 1 on the last flit only.
- R6: For kinds 2'b00 and 2'b01, `cmd_address_o[39:26]` holds the target identifier. Bit 3 is 1 for update and 0 for invalidate. Bit 2 equals `req_inst_i`. All other address bits are 0.
- R7: For kind 2'b10, `cmd_address_o[39:20]` holds `req_box_i`, ordered xmin[19:15], xmax[14:10], ymin[9:5], ymax[4:0]. Bits [1:0] are 2'b11. All other bits are 0. The target identifier and the cache-type flag have no effect.
- R8: A flit moves on only on a cycle where valid and ready are both high. While valid is high and ready is low, the flit stays unchanged.
- R9: `req_ready_o` is 0 while a packet is in flight. It returns to 1 in the cycle after the last flit's handshake.
- R10: An update with N = 0, or a request of kind 2'b11, is accepted but produces no flit. `err_o` is then high for exactly the one cycle after acceptance.
- R11: An update with N > 16 is sent with 16 data words (18 flits). `err_o` is high for the one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (idle) |
| req_kind_i | input | 2 | 00 invalidate, 01 update, 10 broadcast, 11 reserved |
| req_line_i | input | 34 | Line index |
| req_tgt_i | input | 14 | Target L1 identifier |
| req_inst_i | input | 1 | 1 = instruction cache, 0 = data cache |
| req_box_i | input | 20 | Broadcast rectangle {xmin,xmax,ymin,ymax} |
| req_first_word_i | input | 4 | Index of first updated word |
| req_count_i | input | 5 | Update word count N |
| req_words_i | input | 512 | Update words, word k at [32k+31:32k] |
| cmd_valid_o | output | 1 | Flit valid |
| cmd_ready_i | input | 1 | Flit ready |
| cmd_cmd_o | output | 2 | Command code |
| cmd_address_o | output | 40 | Flit address |
| cmd_wdata_o | output | 32 | Flit write data |
| cmd_be_o | output | 4 | Flit byte enables |
| cmd_eop_o | output | 1 | Last flit of packet |
| err_o | output | 1 | One-cycle error pulse for a rejected or clamped request |

## Verification
Some properties are checked by assertions on every cycle:
- a stalled flit stays frozen;
- the request port stays closed while flits are pending, and reopens right after an end-of-packet handshake;
- the address stays fixed within a packet and always ends in 00 or 11;
- the first flit leaves the upper byte-enable lanes clear;
- an error pulse appears only right after an acceptance.

Other properties can only be shown by the bench's scenarios against its flit-queue model:
- the exact field contents per kind;
- the packet length for counts 0, 1, 16 and above 16;
- that the target and cache-type inputs have no effect on a broadcast;
- the behaviour under always-ready, random and periodic backpressure.

// File: rtl/coh_cmd_pkg.sv
package coh_cmd_pkg;
  typedef enum logic [1:0] {
    KIND_INVAL  = 2'b00,
    KIND_UPDATE = 2'b01,
    KIND_BCAST  = 2'b10,
    KIND_RSVD   = 2'b11
  } coh_kind_e;

  localparam logic [1:0] VCI_CMD_WRITE = 2'b10;
endpackage

// File: rtl/coh_addr_build.sv
module coh_addr_build
  import coh_cmd_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int SRCID_W = 14,
  parameter int BOX_W   = 20
) (
  input  coh_kind_e           kind_i,
  input  logic [SRCID_W-1:0]  tgt_i,
  input  logic                inst_i,
  input  logic [BOX_W-1:0]    box_i,
  output logic [ADDR_W-1:0]   addr_o
);
  always_comb begin
    addr_o = '0;
    if (kind_i == KIND_BCAST) begin
      addr_o[ADDR_W-1 -: BOX_W] = box_i;
      addr_o[1:0]               = 2'b11;
    end else begin
      addr_o[ADDR_W-1 -: SRCID_W] = tgt_i;
      addr_o[3]                   = (kind_i == KIND_UPDATE);
      addr_o[2]                   = inst_i;
    end
  end
endmodule

// File: rtl/coh_flit_mux.sv
module coh_flit_mux #(
  parameter int DATA_W    = 32,
  parameter int LINE_W    = 34,
  parameter int MAX_WORDS = 16,
  parameter int CNT_W     = 5,
  parameter int WIDX_W    = 4,
  localparam int BE_W     = DATA_W / 8,
  localparam int HI_W     = LINE_W - DATA_W
) (
  input  logic [CNT_W-1:0]   flit_idx_i,
  input  logic [LINE_W-1:0]  line_i,
  input  logic [WIDX_W-1:0]  first_word_i,
  input  logic [DATA_W-1:0]  words_i [MAX_WORDS],
  output logic [DATA_W-1:0]  wdata_o,
  output logic [BE_W-1:0]    be_o
);
  always_comb begin
    wdata_o = '0;
    be_o    = '1;
    if (flit_idx_i == '0) begin
      wdata_o         = line_i[DATA_W-1:0];
      be_o            = '0;
      be_o[HI_W-1:0]  = line_i[LINE_W-1:DATA_W];
    end else if (flit_idx_i == CNT_W'(1)) begin
      wdata_o = DATA_W'(first_word_i);
    end else begin
      for (int k = 0; k < MAX_WORDS; k++) begin
        if (flit_idx_i == CNT_W'(k + 2)) wdata_o = words_i[k];
      end
    end
  end
endmodule

// File: rtl/coh_pkt_seq.sv
module coh_pkt_seq
  import coh_cmd_pkg::*;
#(
  parameter int MAX_WORDS = 16,
  parameter int CNT_W     = 5,
  parameter int NREQ_W    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  coh_kind_e          req_kind_i,
  input  logic [NREQ_W-1:0]  req_count_i,
  output logic               req_ready_o,
  output logic               load_o,
  input  logic               cmd_ready_i,
  output logic               cmd_valid_o,
  output logic               cmd_eop_o,
  output logic [CNT_W-1:0]   flit_idx_o,
  output logic               err_o
);
  typedef enum logic {ST_IDLE, ST_SEND} st_e;

  st_e              state_q;
  logic [CNT_W-1:0] idx_q, last_q, last_d;
  logic             err_q;
  logic             accept, reject, clamp, fire;
  logic [NREQ_W-1:0] n_eff;

  assign req_ready_o = (state_q == ST_IDLE);
  assign cmd_valid_o = (state_q == ST_SEND);
  assign cmd_eop_o   = cmd_valid_o && (idx_q == last_q);
  assign flit_idx_o  = idx_q;
  assign err_o       = err_q;
  assign accept      = req_valid_i && req_ready_o;
  assign load_o      = accept;
  assign fire        = cmd_valid_o && cmd_ready_i;

  assign reject = (req_kind_i == KIND_RSVD) ||
                  (req_kind_i == KIND_UPDATE && req_count_i == '0);
  assign clamp  = (req_kind_i == KIND_UPDATE) && (req_count_i > NREQ_W'(MAX_WORDS));
  assign n_eff  = clamp ? NREQ_W'(MAX_WORDS) : req_count_i;

  always_comb begin
    last_d = '0;
    if (req_kind_i == KIND_UPDATE) last_d = CNT_W'(n_eff) + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= accept && (reject || clamp);
      case (state_q)
        ST_IDLE: if (accept && !reject) begin
          state_q <= ST_SEND;
          idx_q   <= '0;
          last_q  <= last_d;
        end
        ST_SEND: if (fire) begin
          if (idx_q == last_q) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coh_cmd_gen.sv
module coh_cmd_gen
  import coh_cmd_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int DATA_W    = 32,
  parameter int LINE_W    = 34,
  parameter int SRCID_W   = 14,
  parameter int BOX_W     = 20,
  parameter int MAX_WORDS = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic [1:0]                    req_kind_i,
  input  logic [LINE_W-1:0]             req_line_i,
  input  logic [SRCID_W-1:0]            req_tgt_i,
  input  logic                          req_inst_i,
  input  logic [BOX_W-1:0]              req_box_i,
  input  logic [$clog2(MAX_WORDS)-1:0]  req_first_word_i,
  input  logic [$clog2(MAX_WORDS):0]    req_count_i,
  input  logic [MAX_WORDS*DATA_W-1:0]   req_words_i,
  output logic                          cmd_valid_o,
  input  logic                          cmd_ready_i,
  output logic [1:0]                    cmd_cmd_o,
  output logic [ADDR_W-1:0]             cmd_address_o,
  output logic [DATA_W-1:0]             cmd_wdata_o,
  output logic [DATA_W/8-1:0]           cmd_be_o,
  output logic                          cmd_eop_o,
  output logic                          err_o
);
  localparam int WIDX_W = $clog2(MAX_WORDS);
  localparam int NREQ_W = WIDX_W + 1;
  localparam int CNT_W  = $clog2(MAX_WORDS + 2);

  coh_kind_e           kind_in, kind_q;
  logic                load;
  logic [CNT_W-1:0]    flit_idx;
  logic [LINE_W-1:0]   line_q;
  logic [SRCID_W-1:0]  tgt_q;
  logic                inst_q;
  logic [BOX_W-1:0]    box_q;
  logic [WIDX_W-1:0]   fw_q;
  logic [DATA_W-1:0]   words_q [MAX_WORDS];

  assign kind_in   = coh_kind_e'(req_kind_i);
  assign cmd_cmd_o = VCI_CMD_WRITE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= KIND_INVAL;
      line_q <= '0;
      tgt_q  <= '0;
      inst_q <= 1'b0;
      box_q  <= '0;
      fw_q   <= '0;
    end else if (load) begin
      kind_q <= kind_in;
      line_q <= req_line_i;
      tgt_q  <= req_tgt_i;
      inst_q <= req_inst_i;
      box_q  <= req_box_i;
      fw_q   <= req_first_word_i;
    end
  end

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   words_q[g] <= '0;
      else if (load) words_q[g] <= req_words_i[g*DATA_W +: DATA_W];
    end
  end

  coh_pkt_seq #(
    .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W), .NREQ_W(NREQ_W)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (kind_in),
    .req_count_i (req_count_i),
    .req_ready_o (req_ready_o),
    .load_o      (load),
    .cmd_ready_i (cmd_ready_i),
    .cmd_valid_o (cmd_valid_o),
    .cmd_eop_o   (cmd_eop_o),
    .flit_idx_o  (flit_idx),
    .err_o       (err_o)
  );

  coh_addr_build #(
    .ADDR_W(ADDR_W), .SRCID_W(SRCID_W), .BOX_W(BOX_W)
  ) i_addr (
    .kind_i (kind_q),
    .tgt_i  (tgt_q),
    .inst_i (inst_q),
    .box_i  (box_q),
    .addr_o (cmd_address_o)
  );

  coh_flit_mux #(
    .DATA_W(DATA_W), .LINE_W(LINE_W), .MAX_WORDS(MAX_WORDS),
    .CNT_W(CNT_W), .WIDX_W(WIDX_W)
  ) i_mux (
    .flit_idx_i   (flit_idx),
    .line_i       (line_q),
    .first_word_i (fw_q),
    .words_i      (words_q),
    .wdata_o      (cmd_wdata_o),
    .be_o         (cmd_be_o)
  );
endmodule

// File: rtl/coh_cmd_gen_chk.sv
module coh_cmd_gen_chk #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 32,
  parameter int HI_W   = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_ready_o,
  input logic                  cmd_valid_o,
  input logic                  cmd_ready_i,
  input logic [ADDR_W-1:0]     cmd_address_o,
  input logic [DATA_W-1:0]     cmd_wdata_o,
  input logic [DATA_W/8-1:0]   cmd_be_o,
  input logic                  cmd_eop_o,
  input logic                  err_o
);
  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_address_o) &&
    $stable(cmd_wdata_o) && $stable(cmd_be_o) && $stable(cmd_eop_o));

  // R9
  busy_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !req_ready_o);

  // R9
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i && cmd_eop_o |=> req_ready_o && !cmd_valid_o);

  // R10
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i && req_ready_o));

  // R6
  addr_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_address_o[1:0] == 2'b00 || cmd_address_o[1:0] == 2'b11));

  // R5
  addr_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && $past(cmd_valid_o) |-> $stable(cmd_address_o));

  // R3
  first_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> (cmd_be_o >> HI_W) == '0);
endmodule

bind coh_cmd_gen coh_cmd_gen_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_W(LINE_W - DATA_W)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .cmd_valid_o   (cmd_valid_o),
  .cmd_ready_i   (cmd_ready_i),
  .cmd_address_o (cmd_address_o),
  .cmd_wdata_o   (cmd_wdata_o),
  .cmd_be_o      (cmd_be_o),
  .cmd_eop_o     (cmd_eop_o),
  .err_o         (err_o)
);

// File: tb/test_coh_cmd_gen.sv
module test_coh_cmd_gen;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [1:0]   req_kind_i = '0;
  logic [33:0]  req_line_i = '0;
  logic [13:0]  req_tgt_i = '0;
  logic         req_inst_i = 1'b0;
  logic [19:0]  req_box_i = '0;
  logic [3:0]   req_first_word_i = '0;
  logic [4:0]   req_count_i = '0;
  logic [511:0] req_words_i = '0;
  logic         cmd_valid_o;
  logic         cmd_ready_i = 1'b0;
  logic [1:0]   cmd_cmd_o;
  logic [39:0]  cmd_address_o;
  logic [31:0]  cmd_wdata_o;
  logic [3:0]   cmd_be_o;
  logic         cmd_eop_o;
  logic         err_o;

  int checks = 0, errors = 0, cyc = 0, mode = 0;
  bit mon_on = 0, err_pend = 0;

  logic [39:0] q_addr[$];
  logic [31:0] q_wdata[$];
  logic [3:0]  q_be[$];
  logic        q_eop[$];
  string       q_tag[$];

  always #10 clk_i = ~clk_i;

  coh_cmd_gen i_coh_cmd_gen (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word_of(input int k, input int seed);
    return 32'hA500_0000 ^ (32'(seed) << 8) ^ 32'(k);
  endfunction

  task automatic push(input logic [39:0] a, input logic [31:0] d, input logic [3:0] b,
                      input logic e, input string t);
    q_addr.push_back(a); q_wdata.push_back(d); q_be.push_back(b);
    q_eop.push_back(e); q_tag.push_back(t);
  endtask

  task automatic send(input logic [1:0] kind, input logic [33:0] line, input logic [13:0] tgt,
                      input bit inst, input logic [19:0] box, input logic [3:0] fw,
                      input int n, input int seed);
    logic [39:0] a;
    int ne;
    @(negedge clk_i);
    req_kind_i = kind; req_line_i = line; req_tgt_i = tgt; req_inst_i = inst;
    req_box_i = box; req_first_word_i = fw; req_count_i = 5'(n);
    for (int k = 0; k < 16; k++) req_words_i[k*32 +: 32] = word_of(k, seed);
    req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1;
    req_valid_i = 1'b0;
    if (kind == 2'b11 || (kind == 2'b01 && n == 0)) begin
      err_pend = 1;  // R10
      return;
    end
    err_pend = (kind == 2'b01 && n > 16);  // R11
    ne = (n > 16) ? 16 : n;
    a = '0;
    if (kind == 2'b10) begin
      a[39:20] = box; a[1:0] = 2'b11;  // R7
    end else begin
      a[39:26] = tgt; a[3] = (kind == 2'b01); a[2] = inst;  // R6
    end
    push(a, line[31:0], {2'b00, line[33:32]}, kind != 2'b01, "R3/R4/R6/R7");
    if (kind == 2'b01) begin
      push(a, {28'd0, fw}, 4'hF, 1'b0, "R5 index flit");
      for (int k = 0; k < ne; k++)
        push(a, word_of(k, seed), 4'hF, k == ne - 1, "R5/R11 data flit");
    end
  endtask

  always @(negedge clk_i) if (mon_on) begin
    bit rdy;
    case (mode)
      0: rdy = 1'b1;
      1: rdy = 1'($urandom % 2);
      default: rdy = (cyc % 3) != 0;
    endcase
    cmd_ready_i = rdy;
    chk(req_ready_o == (q_addr.size() == 0), "R9 req_ready", 64'(req_ready_o), 64'(q_addr.size() == 0));
    chk(err_o == err_pend, "R10/R11 err", 64'(err_o), 64'(err_pend));
    err_pend = 0;
    chk(cmd_valid_o == (q_addr.size() != 0), "R8 cmd_valid", 64'(cmd_valid_o), 64'(q_addr.size() != 0));
    if (cmd_valid_o && q_addr.size() != 0) begin
      chk(cmd_cmd_o == 2'b10, "R2 cmd", 64'(cmd_cmd_o), 64'(2'b10));
      chk(cmd_address_o == q_addr[0], {q_tag[0], " addr"}, 64'(cmd_address_o), 64'(q_addr[0]));
      chk(cmd_wdata_o == q_wdata[0], {q_tag[0], " wdata"}, 64'(cmd_wdata_o), 64'(q_wdata[0]));
      chk(cmd_be_o == q_be[0], {q_tag[0], " be"}, 64'(cmd_be_o), 64'(q_be[0]));
      chk(cmd_eop_o == q_eop[0], {q_tag[0], " eop"}, 64'(cmd_eop_o), 64'(q_eop[0]));
      if (rdy) begin
        void'(q_addr.pop_front()); void'(q_wdata.pop_front()); void'(q_be.pop_front());
        void'(q_eop.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 50000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1 during reset
    chk(!cmd_valid_o && req_ready_o && !err_o, "R1 in reset", {cmd_valid_o, req_ready_o, err_o}, 3'b010);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 after release
    chk(!cmd_valid_o && req_ready_o && !err_o, "R1 after reset", {cmd_valid_o, req_ready_o, err_o}, 3'b010);
    mon_on = 1;
    for (int m = 0; m < 3; m++) begin
      mode = m;
      send(2'b00, 34'h2_1234_5678, 14'h3FFF, 1'b0, 20'h0, 4'h0, 0, 1);      // R4 R6 data inval
      send(2'b00, 34'h1_8000_0001, 14'h0005, 1'b1, 20'h0, 4'h0, 0, 2);      // R6 inst inval
      send(2'b10, 34'h3_FFFF_FFFF, 14'h1ABC, 1'b1, 20'hF_8421, 4'h0, 0, 3); // R7 tgt ignored
      send(2'b01, 34'h0_0000_00AA, 14'h0123, 1'b0, 20'h0, 4'h7, 1, 4);      // R5 N=1
      send(2'b01, 34'h2_CAFE_F00D, 14'h2222, 1'b1, 20'hFFFFF, 4'hF, 16, 5); // R5 N=16
      send(2'b01, 34'h0_0000_0000, 14'h0001, 1'b0, 20'h0, 4'h3, 0, 6);      // R10 N=0
      send(2'b11, 34'h1_1111_1111, 14'h0001, 1'b0, 20'h0, 4'h0, 3, 7);      // R10 reserved
      send(2'b01, 34'h1_0F0F_0F0F, 14'h0777, 1'b0, 20'h0, 4'h2, 20, 8);     // R11 clamp
      send(2'b01, 34'h3_0000_0001, 14'h0042, 1'b1, 20'h0, 4'h1, 31, 9);     // R11 clamp max
      send(2'b10, 34'h0_DEAD_BEEF, 14'h0000, 1'b0, 20'h1_0001, 4'h0, 0, 10); // R7
    end
    while (q_addr.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    mon_on = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule